// File: doc/BRIEF.md
# Power Management Status and Control Register

This block is an 8-bit status and control register for the power manager of a small microcontroller. It keeps two sticky flags. One flag reports a low-voltage warning seen by an external comparator. The other reports that the device has come back from partial power-down. Each flag has its own write-one acknowledge bit. The low-voltage warning can only be acknowledged once the warning condition has gone away.

Two control bits decide how a stop request is carried out. One bit enables the power-down stop modes. The other chooses between full and partial power-down. Both bits can be written only once after reset. A lock bit sets on the first register write, and later writes reach only the acknowledge bits.

The comparator output is asynchronous, so it passes through a synchronizer before it sets the flag. While a stop request is held, the block drives a 2-bit code that names the stop depth to be entered.

Top module: `pwr_stat_ctl`

## Requirements
- R1: After reset, with the comparator input low, `rd_data` reads 8'h00 and `stop_mode` is 2'b00.
- R2: The warning flag (read bit 7) is 1 on the third rising clock edge after `lvw_in` rises. This includes the case where `lvw_in` is already high when reset is released.
- R3: Once set, the warning flag stays 1 after `lvw_in` falls, until an acknowledge clears it.
- R4: A write with bit 6 = 1 clears the warning flag at the next edge only if the synchronized warning is low. If the synchronized warning is still high, the flag stays 1.
- R5: The partial power-down flag (read bit 3) is 1 on the edge after a cycle with `stop2_exit` high. A write with bit 2 = 1 clears it. If `stop2_exit` and that write fall in the same cycle, the flag stays 1.
- R6: The first write after reset loads the power-down enable (bit 1) and the mode select (bit 0). Every later write leaves both bits unchanged.
- R7: Read bits 6, 5, 4 and 2 always read 0. A write of 0 to an acknowledge bit leaves both flags unchanged.
- R8: With `stop_req` low, `stop_mode` = 2'b00. With `stop_req` high and the enable at 0, `stop_mode` = 2'b01 (shallow stop). With the enable at 1, `stop_mode` = 2'b11 when select = 0 (full power-down) and 2'b10 when select = 1 (partial power-down).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Address-decoded write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| lvw_in | input | 1 | Asynchronous low-voltage warning from the comparator |
| stop2_exit | input | 1 | One-cycle event: the device has left partial power-down |
| stop_req | input | 1 | A stop mode is being requested |
| stop_mode | output | 2 | Encoded stop depth (see R8) |

## Verification
The bench goes after four corner cases.

- **Acknowledge while the warning is still present.** It acknowledges while the raw comparator is high, and again just after the comparator falls while the synchronizer still holds a 1. A design that cleared the flag unconditionally would drop a warning that is still active.
- **Event and acknowledge together.** It fires a stop2 exit in the same cycle as that flag's acknowledge. A design that let the clear win would lose a recovery event.
- **Write-once controls.** It rewrites the control bits after the first write, and resets in between so that each stop encoding can be reached. A design without a working lock would let software change the power-down depth later.
- **Comparator high through reset.** It holds the comparator high across a reset release. An edge-triggered flag would miss that warning entirely.

// File: rtl/pwr_stat_ctl.sv
module pwr_stat_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       lvw_in,
  input  logic       stop2_exit,
  input  logic       stop_req,
  output logic [1:0] stop_mode
);

  localparam int WARN_BIT   = 7;
  localparam int WACK_BIT   = 6;
  localparam int PPD_BIT    = 3;
  localparam int PACK_BIT   = 2;
  localparam int EN_BIT     = 1;
  localparam int SEL_BIT    = 0;

  logic [SYNC_STAGES-1:0] lvw_pipe;
  logic lvw_sync;
  logic warn_q, ppd_q, pd_en_q, pd_sel_q, lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvw_pipe <= '0;
    else        lvw_pipe <= {lvw_pipe[SYNC_STAGES-2:0], lvw_in};
  end

  assign lvw_sync = lvw_pipe[SYNC_STAGES-1];

  wire warn_ack = wr_en & wr_data[WACK_BIT];
  wire ppd_ack  = wr_en & wr_data[PACK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q   <= 1'b0;
      ppd_q    <= 1'b0;
      pd_en_q  <= 1'b0;
      pd_sel_q <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      warn_q <= lvw_sync | (warn_q & ~warn_ack);
      ppd_q  <= stop2_exit | (ppd_q & ~ppd_ack);
      if (wr_en) lock_q <= 1'b1;
      if (wr_en && !lock_q) begin
        pd_en_q  <= wr_data[EN_BIT];
        pd_sel_q <= wr_data[SEL_BIT];
      end
    end
  end

  assign rd_data = {warn_q, 3'b000, ppd_q, 1'b0, pd_en_q, pd_sel_q};

  assign stop_mode = !stop_req ? 2'b00 :
                     !pd_en_q  ? 2'b01 :
                     pd_sel_q  ? 2'b10 : 2'b11;

endmodule

module pwr_stat_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       stop2_exit,
  input logic       stop_req,
  input logic [1:0] stop_mode,
  input logic       lvw_sync,
  input logic       lock_q
);

  // R2
  warn_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvw_sync |=> rd_data[7]);

  // R3
  warn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && !(wr_en && wr_data[6])) |=> rd_data[7]);

  // R4
  warn_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[6] && !lvw_sync) |=> !rd_data[7]);

  // R5
  ppd_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop2_exit |=> rd_data[3]);

  // R6
  ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || lock_q) |=> $stable(rd_data[1:0]));

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[6:4] == 3'b000) && !rd_data[2]);

  // R8
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_req |-> stop_mode == 2'b00);

  // R8
  shallow_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !rd_data[1]) |-> stop_mode == 2'b01);

endmodule

bind pwr_stat_ctl pwr_stat_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .stop2_exit(stop2_exit), .stop_req(stop_req),
  .stop_mode(stop_mode), .lvw_sync(lvw_sync), .lock_q(lock_q)
);

// File: tb/pwr_stat_ctl_tb.sv
`timescale 1ns/1ps
module pwr_stat_ctl_tb;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       lvw_in = 0;
  logic       stop2_exit = 0;
  logic       stop_req = 0;
  logic [1:0] stop_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_stat_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .lvw_in(lvw_in), .stop2_exit(stop2_exit),
    .stop_req(stop_req), .stop_mode(stop_mode)
  );

  int m_s1, m_s2, m_warn, m_ppd, m_en, m_sel, m_lock;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_mode();
    if (!stop_req) return 0;
    if (m_en == 0) return 1;
    return (m_sel != 0) ? 2 : 3;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_warn = 0; m_ppd = 0;
      m_en = 0; m_sel = 0; m_lock = 0;
    end else begin
      int n_warn, n_ppd;
      n_warn = (m_s2 != 0 || (m_warn != 0 && !(wr_en && wr_data[6]))) ? 1 : 0;
      n_ppd  = (stop2_exit || (m_ppd != 0 && !(wr_en && wr_data[2]))) ? 1 : 0;
      if (wr_en && m_lock == 0) begin
        m_en  = wr_data[1];
        m_sel = wr_data[0];
      end
      if (wr_en) m_lock = 1;
      m_s2 = m_s1;
      m_s1 = lvw_in;
      m_warn = n_warn;
      m_ppd = n_ppd;
      #2;
      if (!done) begin
        chk(rd_data[7] == m_warn, "R2/R3/R4 warn", rd_data[7], m_warn);
        chk(rd_data[3] == m_ppd, "R5 ppd", rd_data[3], m_ppd);
        chk(rd_data[1:0] == 2'(m_en * 2 + m_sel), "R6 ctrl", rd_data[1:0], m_en * 2 + m_sel);
        chk({rd_data[6:4], rd_data[2]} == 4'b0, "R7 zero bits", {rd_data[6:4], rd_data[2]}, 0);
        chk(stop_mode == 2'(exp_mode()), "R8 mode", stop_mode, exp_mode());
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    cyc(2);
    rst_n = 1;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1
    chk(rd_data == 8'h00, "R1 reset rd", rd_data, 0);
    chk(stop_mode == 2'b00, "R1 reset mode", stop_mode, 0);
    stop_req = 1;
    cyc(1);
    chk(stop_mode == 2'b01, "R8 disabled shallow", stop_mode, 1);

    wr(8'h03);
    chk(stop_mode == 2'b10, "R8 partial", stop_mode, 2);
    wr(8'h00);
    chk(rd_data[1:0] == 2'b11, "R6 relocked", rd_data[1:0], 3);
    stop_req = 0;

    lvw_in = 1;
    cyc(2);
    chk(rd_data[7] == 0, "R2 latency early", rd_data[7], 0);
    cyc(1);
    chk(rd_data[7] == 1, "R2 latency", rd_data[7], 1);
    wr(8'h40);
    chk(rd_data[7] == 1, "R4 ack while present", rd_data[7], 1);
    lvw_in = 0;
    wr(8'h40);
    chk(rd_data[7] == 1, "R4 ack while sync high", rd_data[7], 1);
    cyc(4);
    chk(rd_data[7] == 1, "R3 sticky", rd_data[7], 1);
    wr(8'h00);
    chk(rd_data[7] == 1, "R7 zero write", rd_data[7], 1);
    wr(8'h40);
    chk(rd_data[7] == 0, "R4 ack clears", rd_data[7], 0);

    @(negedge clk); stop2_exit = 1;
    @(negedge clk); stop2_exit = 0;
    chk(rd_data[3] == 1, "R5 set", rd_data[3], 1);
    wr(8'hBB);
    chk(rd_data[3] == 1, "R7 zero ack ppd", rd_data[3], 1);
    @(negedge clk); stop2_exit = 1; wr_en = 1; wr_data = 8'h04;
    @(negedge clk); stop2_exit = 0; wr_en = 0; wr_data = 0;
    chk(rd_data[3] == 1, "R5 set wins", rd_data[3], 1);
    wr(8'hFF);
    chk(rd_data[3] == 0, "R5 ack clears", rd_data[3], 0);
    chk(rd_data[1:0] == 2'b11, "R6 ff ignored", rd_data[1:0], 3);

    lvw_in = 1;
    do_reset();
    cyc(3);
    chk(rd_data[7] == 1, "R2 high at reset", rd_data[7], 1);
    lvw_in = 0;
    wr(8'h01);
    wr(8'h02);
    stop_req = 1;
    cyc(1);
    chk(stop_mode == 2'b01, "R6/R8 select only", stop_mode, 1);
    stop_req = 0;

    do_reset();
    wr(8'h02);
    stop_req = 1;
    cyc(1);
    chk(stop_mode == 2'b11, "R8 full", stop_mode, 3);
    stop_req = 0;
    cyc(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    done = 1;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule